// File: doc/BRIEF.md
# Read Request to AXI4 Burst Adapter

This block sits between user logic that wants to read a run of words from external memory and an AXI4 master read port. The user gives a start address and a word count and raises a request flag. When the block's ready flag is high, it takes the request on that edge. It then issues as many incrementing AR bursts as the count needs. No burst is longer than 256 beats, and each split burst starts where the one before it ended. Each returned beat goes back to the user as a word with a valid flag.

The raw read-valid and the response code of every beat are passed out unchanged, for diagnosis. The user may hold off data with an optional ready input. The block keeps a count of beats still owed, so a beat that arrives while nothing is outstanding is never accepted. The ready flag is low from the edge that takes a request until the edge that hands over its last AR burst. When the flag is high, the next request can be presented straight away.

Top module: `rdb_read_adapter`

## Requirements
- R1: During reset and in the first cycle after it, `req_ready` is 1, `m_arvalid` is 0 and `dout_valid` is 0.
- R2: A request with a count from 1 to 256 produces exactly one AR burst in the cycle after it is taken. The burst has `m_araddr` equal to the request address and `m_arlen` equal to the count minus 1. It also has `m_arsize` equal to log2 of the data width in bytes (3 for 64 bits) and `m_arburst` equal to 2'b01 (incrementing).
- R3: A request with a count above 256 produces ceil(count/256) AR bursts, in address order. Each burst's address is the previous one plus 256 times the data width in bytes. Every burst has `m_arlen` 255 except the last, whose `m_arlen` is the remaining count minus 1.
- R4: `req_ready` is 0 from the edge that takes a request until the AR handshake of its last burst. A request presented while `req_ready` is 0 is ignored and issues no burst.
- R5: While `m_arvalid` is 1 and `m_arready` is 0, the next cycle still has `m_arvalid` 1 with the same `m_araddr` and `m_arlen`.
- R6: A request with count 0 is taken but issues no burst, and `req_ready` stays 1.
- R7: `m_rready` is 1 only when `user_dready` is 1. `dout_valid` is 1 exactly when `m_rvalid` and `m_rready` are both 1, with `dout` equal to `m_rdata`. Across a request, the user sees the words for addresses start, start+bytes, and so on, once each and in order.
- R8: `diag_rvalid` equals `m_rvalid` and `diag_rresp` equals `m_rresp` in every cycle, whatever the state of `m_rready`.
- R9: When `req_ready` is 1, a request presented in that cycle is taken at the next edge, and its first AR burst is valid in the cycle that follows.
- R10: While no requested beat is still outstanding, `m_rready` is 0, so a stray read beat is neither accepted nor shown on `dout_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | User read request flag |
| req_addr | input | ADDR_W | Start byte address of the request |
| req_len | input | LEN_W | Number of words to read |
| req_ready | output | 1 | Request will be taken this cycle |
| user_dready | input | 1 | User can take a word (tie high if unused) |
| dout | output | DATA_W | Returned word |
| dout_valid | output | 1 | `dout` holds a word for the user |
| diag_rvalid | output | 1 | Raw read-valid, diagnostic |
| diag_rresp | output | 2 | Raw read response code, diagnostic |
| m_araddr | output | ADDR_W | AR burst address |
| m_arlen | output | 8 | AR burst length minus one |
| m_arsize | output | 3 | AR beat size code |
| m_arburst | output | 2 | AR burst type (incrementing) |
| m_arvalid | output | 1 | AR valid |
| m_arready | input | 1 | AR ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response |
| m_rvalid | input | 1 | Read valid |
| m_rready | output | 1 | Read ready |

## Verification
The hardest case to reach from the ports is a request that arrives while a long request is still splitting. The bench holds the AR ready low on three cycles out of four during a 600-word request, which keeps the split pending. It then raises a second request for several cycles and drops it before the ready flag returns. It checks that only the three expected bursts appear and that only the expected words come back. A stray read beat is driven with nothing outstanding, and the read data is throttled by gaps on both sides of the handshake, so that the beat count must come out right under backpressure.

// File: rtl/rdb_pkg.sv
package rdb_pkg;

  localparam int AXI_LEN_W = 8;
  localparam logic [1:0] BURST_INCR = 2'b01;

  typedef enum logic {
    SPL_IDLE  = 1'b0,
    SPL_ISSUE = 1'b1
  } spl_state_e;

endpackage

// File: rtl/rdb_ar_splitter.sv
module rdb_ar_splitter
  import rdb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 32,
  parameter int BYTES     = 8,
  parameter int MAX_BEATS = 256
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [LEN_W-1:0]     acc_len,
  input  logic                 arready,
  output logic                 arvalid,
  output logic [ADDR_W-1:0]    araddr,
  output logic [AXI_LEN_W-1:0] arlen,
  output logic                 idle
);

  localparam logic [LEN_W-1:0]  CAP  = LEN_W'(MAX_BEATS);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(MAX_BEATS * BYTES);

  spl_state_e             state_q;
  logic [LEN_W-1:0]       left_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [AXI_LEN_W-1:0]   len_q;
  logic [LEN_W-1:0]       first_beats;
  logic [LEN_W-1:0]       next_beats;

  // size of the opening burst and of the following one
  assign first_beats = (acc_len > CAP) ? CAP : acc_len;
  assign next_beats  = (left_q  > CAP) ? CAP : left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SPL_IDLE;
      left_q  <= '0;
      addr_q  <= '0;
      len_q   <= '0;
    end else begin
      case (state_q)
        SPL_IDLE: begin
          if (acc && (acc_len != '0)) begin
            state_q <= SPL_ISSUE;
            addr_q  <= acc_addr;
            len_q   <= AXI_LEN_W'(first_beats - 1'b1);
            left_q  <= acc_len - first_beats;
          end
        end
        SPL_ISSUE: begin
          if (arready) begin
            if (left_q != '0) begin
              addr_q <= addr_q + STEP;
              len_q  <= AXI_LEN_W'(next_beats - 1'b1);
              left_q <= left_q - next_beats;
            end else begin
              state_q <= SPL_IDLE;
            end
          end
        end
        default: state_q <= SPL_IDLE;
      endcase
    end
  end

  assign arvalid = (state_q == SPL_ISSUE);
  assign araddr  = addr_q;
  assign arlen   = len_q;
  assign idle    = (state_q == SPL_IDLE);

endmodule

// File: rtl/rdb_beat_tracker.sv
module rdb_beat_tracker #(
  parameter int LEN_W  = 32,
  parameter int CNT_W  = 40,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic [LEN_W-1:0]  acc_len,
  input  logic              dready,
  input  logic              rvalid,
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        rresp,
  output logic              rready,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid,
  output logic              diag_rvalid,
  output logic [1:0]        diag_rresp
);

  logic [CNT_W-1:0] owed_q;
  logic             beat;
  logic [CNT_W-1:0] add_amt;
  logic [CNT_W-1:0] sub_amt;

  assign rready  = dready && (owed_q != '0);
  assign beat    = rvalid && rready;
  assign add_amt = acc  ? CNT_W'(acc_len) : '0;
  assign sub_amt = beat ? CNT_W'(1)       : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q <= '0;
    end else begin
      owed_q <= owed_q + add_amt - sub_amt;
    end
  end

  assign dout        = rdata;
  assign dout_valid  = beat;
  assign diag_rvalid = rvalid;
  assign diag_rresp  = rresp;

endmodule

// File: rtl/rdb_read_adapter.sv
module rdb_read_adapter
  import rdb_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 32,
  parameter int MAX_BEATS  = 256,
  parameter int USE_DREADY = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  input  logic              user_dready,
  output logic [DATA_W-1:0] dout,
  output logic              dout_valid,
  output logic              diag_rvalid,
  output logic [1:0]        diag_rresp,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic [2:0]        m_arsize,
  output logic [1:0]        m_arburst,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rvalid,
  output logic              m_rready
);

  localparam int BYTES = DATA_W / 8;
  localparam int CNT_W = LEN_W + 8;
  localparam logic [2:0] SIZE_CODE = 3'($clog2(BYTES));

  logic acc;
  logic idle;
  logic dready_eff;

  generate
    if (USE_DREADY != 0) begin : g_dready
      assign dready_eff = user_dready;
    end else begin : g_no_dready
      assign dready_eff = 1'b1;
    end
  endgenerate

  assign req_ready = idle;
  assign acc       = req_valid && idle;
  assign m_arsize  = SIZE_CODE;
  assign m_arburst = BURST_INCR;

  rdb_ar_splitter #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .BYTES    (BYTES),
    .MAX_BEATS(MAX_BEATS)
  ) u_split (
    .clk     (clk),
    .rst     (rst),
    .acc     (acc),
    .acc_addr(req_addr),
    .acc_len (req_len),
    .arready (m_arready),
    .arvalid (m_arvalid),
    .araddr  (m_araddr),
    .arlen   (m_arlen),
    .idle    (idle)
  );

  rdb_beat_tracker #(
    .LEN_W (LEN_W),
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
  ) u_track (
    .clk        (clk),
    .rst        (rst),
    .acc        (acc),
    .acc_len    (req_len),
    .dready     (dready_eff),
    .rvalid     (m_rvalid),
    .rdata      (m_rdata),
    .rresp      (m_rresp),
    .rready     (m_rready),
    .dout       (dout),
    .dout_valid (dout_valid),
    .diag_rvalid(diag_rvalid),
    .diag_rresp (diag_rresp)
  );

endmodule

// File: rtl/rdb_read_adapter_chk.sv
module rdb_read_adapter_chk #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 32,
  parameter int MAX_BEATS = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic [ADDR_W-1:0] m_araddr,
  input logic [7:0]        m_arlen,
  input logic              m_rready,
  input logic              user_dready,
  input logic              dout_valid
);

  localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_BEATS);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !m_arvalid && !dout_valid));

  assert_single_burst_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_len != '0) && (req_len <= CAP)) |=>
      (m_arvalid && (m_araddr == $past(req_addr)) &&
       (m_arlen == 8'($past(req_len) - 1'b1))));

  assert_busy_not_ready_R4: assert property (@(posedge clk) disable iff (rst)
    m_arvalid |-> !req_ready);

  assert_ar_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (m_arvalid && !m_arready) |=>
      (m_arvalid && $stable(m_araddr) && $stable(m_arlen)));

  assert_zero_len_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_len == '0)) |=> (req_ready && !m_arvalid));

  assert_rready_follows_R7: assert property (@(posedge clk) disable iff (rst)
    m_rready |-> user_dready);

endmodule

bind rdb_read_adapter rdb_read_adapter_chk #(
  .ADDR_W   (ADDR_W),
  .LEN_W    (LEN_W),
  .MAX_BEATS(MAX_BEATS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_addr   (req_addr),
  .req_len    (req_len),
  .m_arvalid  (m_arvalid),
  .m_arready  (m_arready),
  .m_araddr   (m_araddr),
  .m_arlen    (m_arlen),
  .m_rready   (m_rready),
  .user_dready(user_dready),
  .dout_valid (dout_valid)
);

// File: tb/tb_rdb_read_adapter.sv
module tb_rdb_read_adapter;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 32;
  localparam int BYTES  = DATA_W / 8;
  localparam int STEP   = 256 * BYTES;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic              req_ready;
  logic              user_dready;
  logic [DATA_W-1:0] dout;
  logic              dout_valid;
  logic              diag_rvalid;
  logic [1:0]        diag_rresp;
  logic [ADDR_W-1:0] m_araddr;
  logic [7:0]        m_arlen;
  logic [2:0]        m_arsize;
  logic [1:0]        m_arburst;
  logic              m_arvalid;
  logic              m_arready;
  logic [DATA_W-1:0] m_rdata;
  logic [1:0]        m_rresp;
  logic              m_rvalid;
  logic              m_rready;

  int n_chk = 0;
  int n_fail = 0;

  // stub controls, set by the scenario tasks
  int ar_mode = 0;
  int dr_mode = 0;
  bit r_gap = 0;
  bit inject_stray = 0;

  // stub state
  logic [ADDR_W-1:0] bq_addr [0:63];
  int                bq_len  [0:63];
  int  wp = 0, rp = 0, beat = 0, cyc = 0;
  bit  consumed = 0, hold_prev = 0, stray_on = 0;
  logic [ADDR_W-1:0] h_addr;
  logic [7:0]        h_len;
  longint exp_pending = 0, pend_add = 0;

  // logs
  logic [DATA_W-1:0] obs_data [0:1023];
  logic [DATA_W-1:0] exp_data [0:1023];
  int obs_n = 0, exp_n = 0;
  logic [ADDR_W-1:0] ar_addr_log [0:15];
  int                ar_len_log  [0:15];
  logic [ADDR_W-1:0] ear_addr [0:15];
  int                ear_len  [0:15];
  int ar_n = 0, ear_n = 0;

  rdb_read_adapter #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .MAX_BEATS(256), .USE_DREADY(1)
  ) dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .req_ready(req_ready), .user_dready(user_dready),
    .dout(dout), .dout_valid(dout_valid),
    .diag_rvalid(diag_rvalid), .diag_rresp(diag_rresp),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize),
    .m_arburst(m_arburst), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid),
    .m_rready(m_rready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // memory stub and per-cycle port checks; all driving at the falling edge
  initial begin
    m_arready = 1'b0; m_rvalid = 1'b0; m_rdata = '0; m_rresp = 2'b00;
    user_dready = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst) begin
        m_arready = 1'b0; m_rvalid = 1'b0; user_dready = 1'b1;
        consumed = 0; hold_prev = 0; pend_add = 0; exp_pending = 0;
        continue;
      end
      exp_pending += pend_add;
      if (consumed) exp_pending--;
      pend_add = 0;
      if (hold_prev)
        chk(m_arvalid && m_araddr == h_addr && m_arlen == h_len, "R5",
            "AR held while stalled", longint'(m_araddr), longint'(h_addr));
      if (consumed) begin
        beat++;
        if (beat > bq_len[rp % 64]) begin rp++; beat = 0; end
        m_rvalid = 1'b0;
      end
      if (stray_on && !inject_stray) begin m_rvalid = 1'b0; stray_on = 0; end
      if (!m_rvalid) begin
        if (rp != wp && (!r_gap || (cyc % 3) != 0)) begin
          m_rvalid = 1'b1;
          m_rdata  = DATA_W'(bq_addr[rp % 64] + ADDR_W'(beat * BYTES));
          m_rresp  = 2'(beat);
        end else if (inject_stray && rp == wp) begin
          m_rvalid = 1'b1; m_rdata = 64'hDEAD_BEEF; m_rresp = 2'b10; stray_on = 1;
        end
      end
      case (ar_mode)
        1: m_arready = cyc[0];
        2: m_arready = ((cyc % 4) == 0);
        default: m_arready = 1'b1;
      endcase
      user_dready = (dr_mode == 1) ? ((cyc % 3) != 1) : 1'b1;
      #1;
      if (m_arvalid && m_arready) begin
        if (ar_n < 16) begin ar_addr_log[ar_n] = m_araddr; ar_len_log[ar_n] = int'(m_arlen); end
        ar_n++;
        bq_addr[wp % 64] = m_araddr; bq_len[wp % 64] = int'(m_arlen); wp++;
      end
      hold_prev = m_arvalid && !m_arready;
      h_addr = m_araddr; h_len = m_arlen;
      consumed = m_rvalid && m_rready && !stray_on;
      if (req_valid && req_ready) begin
        pend_add = longint'(req_len);
        for (int i = 0; i < int'(req_len); i++) begin
          if (exp_n < 1024) exp_data[exp_n] = DATA_W'(req_addr + ADDR_W'(i * BYTES));
          exp_n++;
        end
      end
      chk(diag_rvalid == m_rvalid && diag_rresp == m_rresp, "R8", "diagnostic passthrough",
          longint'({diag_rvalid, diag_rresp}), longint'({m_rvalid, m_rresp}));
      chk(dout_valid == (m_rvalid && m_rready) && (!dout_valid || dout == m_rdata), "R7",
          "data valid and word", longint'(dout_valid), longint'(m_rvalid && m_rready));
      chk(m_rready == (user_dready && exp_pending != 0), "R10", "rready vs outstanding",
          longint'(m_rready), longint'(user_dready && exp_pending != 0));
      if (m_arvalid) chk(!req_ready, "R4", "ready low while bursts pending",
                         longint'(req_ready), 0);
      if (dout_valid) begin
        if (obs_n < 1024) obs_data[obs_n] = dout;
        obs_n++;
      end
    end
  end

  task automatic clear_logs();
    obs_n = 0; exp_n = 0; ar_n = 0; ear_n = 0;
  endtask

  task automatic expect_bursts(input logic [ADDR_W-1:0] addr, input int len);
    int rem = len;
    logic [ADDR_W-1:0] a = addr;
    while (rem > 0) begin
      int c = (rem > 256) ? 256 : rem;
      ear_addr[ear_n] = a; ear_len[ear_n] = c - 1; ear_n++;
      a = a + ADDR_W'(STEP); rem -= c;
    end
  endtask

  // call at a falling edge; returns at the falling edge after the request is taken
  task automatic issue(input logic [ADDR_W-1:0] addr, input int len, input string req);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_len = LEN_W'(len);
    expect_bursts(addr, len);
    @(negedge clk);
    req_valid = 1'b0;
    if (len != 0)
      chk(m_arvalid && m_araddr == addr && !req_ready, req,
          "first burst one cycle after accept", longint'(m_araddr), longint'(addr));
    else
      chk(!m_arvalid && req_ready, req, "zero length leaves block idle",
          longint'({m_arvalid, req_ready}), 1);
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk);
      #2;
      if (exp_pending == 0 && pend_add == 0 && rp == wp && !m_arvalid && !m_rvalid) break;
    end
    @(negedge clk);
  endtask

  task automatic compare(input string req);
    chk(ar_n == ear_n, req, "AR burst count", longint'(ar_n), longint'(ear_n));
    for (int i = 0; i < ar_n && i < ear_n && i < 16; i++) begin
      chk(ar_addr_log[i] == ear_addr[i] && ar_len_log[i] == ear_len[i], req,
          "AR burst address/len", longint'(ar_addr_log[i]), longint'(ear_addr[i]));
    end
    chk(obs_n == exp_n, "R7", "word count", longint'(obs_n), longint'(exp_n));
    for (int i = 0; i < obs_n && i < exp_n && i < 1024; i++) begin
      if (obs_data[i] != exp_data[i]) begin
        chk(0, "R7", "word order", longint'(obs_data[i]), longint'(exp_data[i]));
        break;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready && !m_arvalid && !dout_valid, "R1", "state during reset",
        longint'({req_ready, m_arvalid, dout_valid}), 4);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !m_arvalid && !dout_valid, "R1", "state after reset",
        longint'({req_ready, m_arvalid, dout_valid}), 4);
  endtask

  task automatic t_single();
    clear_logs(); ar_mode = 0; dr_mode = 0; r_gap = 0;
    issue(32'h1000, 5, "R2");
    chk(m_arsize == 3'd3 && m_arburst == 2'b01, "R2", "size and burst type",
        longint'({m_arsize, m_arburst}), longint'({3'd3, 2'b01}));
    chk(m_arlen == 8'd4, "R2", "arlen", longint'(m_arlen), 4);
    wait_idle();
    compare("R2");
  endtask

  task automatic t_split();
    clear_logs(); ar_mode = 1;
    issue(32'h0002_0000, 600, "R3");
    wait_idle();
    compare("R3");
    chk(ear_n == 3, "R3", "expected split count", longint'(ear_n), 3);
  endtask

  task automatic t_boundary();
    clear_logs(); ar_mode = 0;
    issue(32'h4000, 256, "R3");
    issue(32'h8000, 257, "R9");
    wait_idle();
    compare("R3");
  endtask

  task automatic t_zero();
    clear_logs();
    issue(32'h7000, 0, "R6");
    @(negedge clk);
    chk(req_ready && !m_arvalid, "R6", "still idle next cycle",
        longint'({req_ready, m_arvalid}), 2);
    wait_idle();
    compare("R6");
  endtask

  task automatic t_backpressure();
    clear_logs(); dr_mode = 1; r_gap = 1; ar_mode = 1;
    issue(32'h3008, 40, "R7");
    wait_idle();
    compare("R7");
    dr_mode = 0; r_gap = 0; ar_mode = 0;
  endtask

  task automatic t_b2b();
    clear_logs(); ar_mode = 0;
    issue(32'h100, 3, "R9");
    issue(32'h5000, 300, "R9");
    wait_idle();
    compare("R9");
  endtask

  task automatic t_busy();
    clear_logs(); ar_mode = 2;
    issue(32'h0004_0000, 600, "R4");
    req_valid = 1'b1; req_addr = 32'h9000; req_len = 7;
    for (int k = 0; k < 3; k++) begin
      #2;
      chk(!req_ready, "R4", "request held while busy", longint'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    wait_idle();
    compare("R4");
    ar_mode = 0;
  endtask

  task automatic t_stray();
    clear_logs();
    inject_stray = 1;
    repeat (4) begin
      @(negedge clk);
      #2;
      chk(m_rvalid && !m_rready && !dout_valid && diag_rvalid, "R10",
          "stray beat refused", longint'({m_rvalid, m_rready, dout_valid, diag_rvalid}), 9);
      chk(diag_rresp == 2'b10, "R8", "stray response forwarded",
          longint'(diag_rresp), 2);
    end
    inject_stray = 0;
    wait_idle();
    chk(obs_n == 0, "R10", "no words seen", longint'(obs_n), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_split();
    t_boundary();
    t_zero();
    t_backpressure();
    t_b2b();
    t_busy();
    t_stray();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule